// File: doc/BRIEF.md
# Selectable Joypad Input Register

This block presents eight push-button inputs to a processor through one byte-wide memory-mapped register. The eight buttons form two groups of four: the direction keys and the action keys. The processor writes a select code to the register to choose which group is visible. After that, every read of the register returns the four state bits of the chosen group in the low nibble.

The raw button lines are asynchronous to the system clock. They pass through a synchroniser before anything uses them. Whenever the synchronised button vector changes, whether by a press or by a release, the block emits a one-cycle pulse on the joypad line of the interrupt request vector. A separate interrupt controller, outside this block, collects that pulse.

Top module: `keypad_port`

## Requirements
- R1: While reset is low, and right after it is released with all buttons at 0, the select state is "no group", reads at the register address return 0x00, and the interrupt request vector is 0.
- R2: After a write of 0x10 to address 0xFF00, reads at 0xFF00 return the synchronised direction bits in bits 3:0, with up=bit0, down=bit1, left=bit2 and right=bit3. Bits 7:4 read 0.
- R3: After a write of 0x20 to 0xFF00, reads at 0xFF00 return the action bits in bits 3:0, with A=bit0, B=bit1, select=bit2 and start=bit3. Bits 7:4 read 0. These four buttons are inputs 7:4 of the button vector.
- R4: A write to 0xFF00 of any value other than 0x10 or 0x20 selects no group, and reads then return 0x00.
- R5: A write to any address other than 0xFF00 leaves the select state unchanged.
- R6: When a button input changes, bit 4 of the 5-bit interrupt request vector is high for exactly one cycle. It rises on the third rising clock edge after the change and falls on the fourth. Bits 3:0 of the vector are always 0.
- R7: Both a press (0 to 1) and a release (1 to 0) of a button raise the request of R6.
- R8: While the button inputs hold steady, no interrupt request is raised.
- R9: A button change becomes visible in read data after the second rising clock edge, and not after the first.
- R10: Reads at any address other than 0xFF00 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btn_i | input | 8 | Raw button levels, 1 = pressed; 3:0 directions, 7:4 actions |
| addr_i | input | 16 | Bus address |
| wr_en_i | input | 1 | Bus write strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_vec_o | output | 5 | Interrupt request vector, joypad request on bit 4 |

## Verification
A corrupted select state shows on the first read at 0xFF00 after the write. That read returns the wrong nibble or a nonzero value where 0 is due, so the fault is visible in the very next cycle. A stale or wrong previous-button copy in the change detector shows within three edges of a stimulus as one of three errors: a missing pulse, a pulse two cycles long, or a pulse with no button change behind it. The bench samples these outputs edge by edge across the synchroniser and detector delay, so a shift of one cycle in either stage also shows.

// File: rtl/keypad_pkg.sv
package keypad_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_ACT  = 2'd2
  } sel_e;

  localparam logic [7:0] CODE_DIR = 8'h10;
  localparam logic [7:0] CODE_ACT = 8'h20;
endpackage

// File: rtl/keypad_sync.sv
module keypad_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/keypad_change_det.sv
module keypad_change_det #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  output logic         pulse_o
);
  logic [W-1:0] prev_q;
  logic         pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= cur_i;
      pulse_q <= (cur_i != prev_q);
    end
  end

  assign pulse_o = pulse_q;

  // R8
  steady_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(cur_i) && $past(cur_i) == $past(prev_q)) |=> !pulse_q);
endmodule

// File: rtl/keypad_mux.sv
module keypad_mux
  import keypad_pkg::*;
#(
  parameter int W      = 8,
  parameter int DATA_W = 8,
  localparam int NIB_W = W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [W-1:0]     btn_i,
  output logic [NIB_W-1:0] nib_o
);
  sel_e sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_i) begin
      unique case (wdata_i)
        CODE_DIR: sel_d = SEL_DIR;
        CODE_ACT: sel_d = SEL_ACT;
        default:  sel_d = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SEL_NONE;
    else         sel_q <= sel_d;
  end

  always_comb begin
    unique case (sel_q)
      SEL_DIR: nib_o = btn_i[NIB_W-1:0];
      SEL_ACT: nib_o = btn_i[W-1:NIB_W];
      default: nib_o = '0;
    endcase
  end

  // R5
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(sel_q));

  // R4
  none_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i != CODE_DIR && wdata_i != CODE_ACT) |=> (nib_o == '0));
endmodule

// File: rtl/keypad_port.sv
module keypad_port #(
  parameter int          NUM_BTN     = 8,
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          IRQ_W       = 5,
  parameter int          IRQ_BIT     = 4,
  parameter logic [15:0] REG_ADDR    = 16'hFF00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_BTN-1:0] btn_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [IRQ_W-1:0]  irq_vec_o
);
  localparam int NIB_W = NUM_BTN / 2;
  localparam logic [IRQ_W-1:0] IRQ_MASK = IRQ_W'(1) << IRQ_BIT;

  logic [NUM_BTN-1:0] btn_sync;
  logic [NIB_W-1:0]   nib;
  logic               hit;
  logic               chg_pulse;

  assign hit = (addr_i == ADDR_W'(REG_ADDR));

  keypad_sync #(.W(NUM_BTN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_i),
    .q_o   (btn_sync)
  );

  keypad_change_det #(.W(NUM_BTN)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (btn_sync),
    .pulse_o(chg_pulse)
  );

  keypad_mux #(.W(NUM_BTN), .DATA_W(DATA_W)) u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en_i && hit),
    .wdata_i(wdata_i),
    .btn_i  (btn_sync),
    .nib_o  (nib)
  );

  assign rdata_o   = hit ? {{(DATA_W-NIB_W){1'b0}}, nib} : '0;
  assign irq_vec_o = chg_pulse ? IRQ_MASK : '0;

  // R6
  irq_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_vec_o[IRQ_BIT] |-> ($past(btn_sync) != $past(btn_sync, 2)));

  // R6
  irq_follows_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btn_sync != $past(btn_sync)) |=> irq_vec_o[IRQ_BIT]);

  // R2
  dir_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit && wdata_i == 8'h10) |=> (!hit || rdata_o == {{(DATA_W-NIB_W){1'b0}}, btn_sync[NIB_W-1:0]}));

  // R3
  act_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit && wdata_i == 8'h20) |=> (!hit || rdata_o == {{(DATA_W-NIB_W){1'b0}}, btn_sync[NUM_BTN-1:NIB_W]}));

  // R10
  miss_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rdata_o == '0));
endmodule

// File: tb/keypad_port_tb.sv
`timescale 1ns/1ps
module keypad_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  btn = '0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [4:0]  irq_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keypad_port u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .btn_i    (btn),
    .addr_i   (addr),
    .wr_en_i  (wr_en),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .irq_vec_o(irq_vec)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 16'h0000;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
    addr = 16'h0000;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset;
    btn = 8'h00;
    #5;
    rd_chk("R1", 16'hFF00, 8'h00);
    chk("R1", {3'b0, irq_vec}, 8'h00);
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
    rd_chk("R1", 16'hFF00, 8'h00);
    chk("R1", {3'b0, irq_vec}, 8'h00);
  endtask

  task automatic t_select;
    @(negedge clk); btn = 8'hA6;
    cyc(5);
    wr(16'hFF00, 8'h10);
    rd_chk("R2", 16'hFF00, 8'h06);
    wr(16'hFF00, 8'h20);
    rd_chk("R3", 16'hFF00, 8'h0A);
    wr(16'hFF00, 8'h30);
    rd_chk("R4", 16'hFF00, 8'h00);
    wr(16'hFF00, 8'h10);
    wr(16'hFF00, 8'h00);
    rd_chk("R4", 16'hFF00, 8'h00);
    wr(16'hFF00, 8'h11);
    rd_chk("R4", 16'hFF00, 8'h00);
  endtask

  task automatic t_other_addr;
    wr(16'hFF00, 8'h20);
    wr(16'hFF01, 8'h10);
    rd_chk("R5", 16'hFF00, 8'h0A);
    wr(16'h7F00, 8'h33);
    rd_chk("R5", 16'hFF00, 8'h0A);
    rd_chk("R10", 16'hFF01, 8'h00);
    rd_chk("R10", 16'hFE00, 8'h00);
  endtask

  // change at a negedge, then sample after each following rising edge
  task automatic t_edge(input string req, input logic [7:0] nb, input logic [7:0] sel,
                        input logic [7:0] old_rd, input logic [7:0] new_rd);
    wr(16'hFF00, sel);
    cyc(4);
    btn = nb;
    @(negedge clk);
    chk(req, {3'b0, irq_vec}, 8'h00);
    rd_chk("R9", 16'hFF00, old_rd);
    @(negedge clk);
    chk(req, {3'b0, irq_vec}, 8'h00);
    rd_chk("R9", 16'hFF00, new_rd);
    @(negedge clk);
    chk("R6", {3'b0, irq_vec}, 8'h10);
    @(negedge clk);
    chk("R6", {3'b0, irq_vec}, 8'h00);
  endtask

  task automatic t_steady;
    int seen = 0;
    cyc(4);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq_vec != 5'h00) seen++;
    end
    chk("R8", 8'(seen), 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    t_reset();
    t_select();
    t_other_addr();
    // R7 press on a direction key
    t_edge("R7", 8'hAE, 8'h10, 8'h06, 8'h0E);
    // R7 release on an action key
    t_edge("R7", 8'h2E, 8'h20, 8'h0A, 8'h02);
    t_steady();
    done = 1'b1;
    report();
  end
endmodule